// File: doc/BRIEF.md
# Supervisor Shadow Stack Token Release Unit

This execution unit retires the privileged operation that hands a supervisor shadow stack token back as free. A decoded request carries the operand linear address, the processor mode, the current privilege level, a flag saying whether a LOCK prefix was present, and two enable bits: the control-register feature enable and the supervisor shadow-stack enable. The unit first screens the request for faults in a fixed order. If the request survives, it runs one atomic 64-bit compare-and-exchange on the token in memory. It does this through a locked read/write handshake. The value it expects to find is the operand address with bit 0, the busy bit, set. The value it writes in its place is the same address with bit 0 clear.

When the operation completes without a fault, the unit hands the outside world a write of the arithmetic flags and a write of zero to the shadow stack pointer. The carry flag reports whether the token was invalid, and every other arithmetic flag is cleared. When a fault is raised, neither write is issued, so the architectural flags and pointer keep whatever values they had. A memory fault seen during the locked access is passed through as the reported fault.

The controller has four states. IDLE accepts a request and latches it, moving to CHECK. CHECK evaluates the faults. It goes to FINISH with a fault code, or it starts the exchange and goes to XCHG. XCHG waits for the exchange to finish or abort, then goes to FINISH. FINISH pulses done for one cycle and returns to IDLE. The exchange engine has its own three states. XIDLE moves to XREAD when started. XREAD waits for the read acknowledge and moves to XWRITE, or returns to XIDLE on a memory fault. XWRITE waits for the write acknowledge and returns to XIDLE, again returning early on a memory fault.

Top module: `ssrel_token_release`

## Requirements
- R1: With req_mode 0 (real-address) or 1 (virtual-8086), the unit reports fault_code 1 (invalid opcode) with fault_cause 1, and issues no memory request.
- R2: In other modes, the invalid-opcode checks are made in this order: LOCK prefix present (cause 2), control enable clear (cause 3), supervisor shadow-stack enable clear (cause 4). Each reports fault_code 1 with no memory request, and each outranks every general-protection check.
- R3: A privilege level other than 0 reports fault_code 2 (general protection) with cause 5. This check outranks the canonical-form and alignment checks.
- R4: In req_mode 3 (64-bit), an address whose bits from VA_BITS-1 up to the top are not all equal reports fault_code 2 with cause 6, ahead of the alignment check. In req_mode 2 the canonical form is not checked.
- R5: An address with any of its low log2(ALIGN_BYTES) bits set reports fault_code 2 with cause 7.
- R6: The exchange issues one read and then one write to the operand address. mem_lock stays high from the read request through the write acknowledge, and drops in the following cycle.
- R7: When the value read equals the address with bit 0 set, the value written is the address with bit 0 clear.
- R8: When the value read differs from that expected value, the value read is written back unchanged.
- R9: When the operation completes without a fault, flags_we and ssp_we are high with done, and ssp_next is 0. flag_cf is 1 for an invalid token and 0 for a valid one, and flag_zf, flag_pf, flag_af, flag_of and flag_sf are all 0.
- R10: done is high for exactly one cycle per request, together with fault_code and fault_cause. With any fault, flags_we and ssp_we stay low.
- R11: mem_fault during the read or write phase aborts the exchange and releases mem_lock. The unit then reports fault_code 3 with cause 9, and no write follows a fault in the read phase.
- R12: With LONG_TOKEN_GP set, an invalid token in req_mode 3 reports fault_code 2 with cause 8, after the unchanged value has been written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_addr | input | ADDR_W | Operand linear address |
| req_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| req_cpl | input | 2 | Current privilege level |
| req_lock_pfx | input | 1 | LOCK prefix was present |
| cfg_ctl_en | input | 1 | Control-register feature enable |
| cfg_sup_ss_en | input | 1 | Supervisor shadow-stack enable |
| mem_rd_req | output | 1 | Locked read request |
| mem_wr_req | output | 1 | Locked write request |
| mem_lock | output | 1 | Bus lock held across the exchange |
| mem_addr | output | ADDR_W | Token address |
| mem_wdata | output | 64 | Value written to the token |
| mem_rdata | input | 64 | Token value read |
| mem_rd_ack | input | 1 | Read acknowledge with data |
| mem_wr_ack | input | 1 | Write acknowledge |
| mem_fault | input | 1 | Memory fault during the access |
| done | output | 1 | One-cycle completion strobe |
| fault_code | output | 2 | 0 none, 1 invalid opcode, 2 general protection, 3 memory |
| fault_cause | output | 4 | Which check fired (see requirements) |
| flags_we | output | 1 | Write enable for the arithmetic flags |
| flag_cf | output | 1 | Carry: invalid token |
| flag_zf | output | 1 | Zero flag value |
| flag_pf | output | 1 | Parity flag value |
| flag_af | output | 1 | Auxiliary-carry flag value |
| flag_of | output | 1 | Overflow flag value |
| flag_sf | output | 1 | Sign flag value |
| ssp_we | output | 1 | Write enable for the shadow stack pointer |
| ssp_next | output | ADDR_W | New shadow stack pointer value |

## Verification
The bench builds the unit with its default parameters: a 64-bit address, 48 significant virtual-address bits, 8-byte alignment, and LONG_TOKEN_GP set. With these values, one address can be made non-canonical and misaligned at the same time. This lets the canonical-before-alignment ordering be observed, and lets the same address pass in protected mode. Because LONG_TOKEN_GP is set, both outcomes of an invalid token can be reached. In protected mode it is reported through the carry flag. In 64-bit mode it raises a general-protection fault after the write-back.

// File: rtl/ssrel_pkg.sv
package ssrel_pkg;

    localparam int TOKEN_W = 64;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_GP   = 2'd2,
        FLT_MEM  = 2'd3
    } fault_e;

    typedef enum logic [3:0] {
        CAUSE_NONE  = 4'd0,
        CAUSE_MODE  = 4'd1,
        CAUSE_LOCK  = 4'd2,
        CAUSE_CTL   = 4'd3,
        CAUSE_SSEN  = 4'd4,
        CAUSE_PRIV  = 4'd5,
        CAUSE_CANON = 4'd6,
        CAUSE_ALIGN = 4'd7,
        CAUSE_TOKEN = 4'd8,
        CAUSE_MEM   = 4'd9
    } cause_e;

endpackage

// File: rtl/ssrel_fault_check.sv
module ssrel_fault_check import ssrel_pkg::*; #(
    parameter int ADDR_W      = 64,
    parameter int VA_BITS     = 48,
    parameter int ALIGN_BYTES = 8
) (
    input  logic [1:0]        mode,
    input  logic              lock_pfx,
    input  logic              ctl_en,
    input  logic              ss_en,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        fault,
    output logic [3:0]        cause
);

    localparam int ALIGN_LSB = (ALIGN_BYTES > 1) ? $clog2(ALIGN_BYTES) : 1;

    logic canonical;
    logic misaligned;
    logic unused_addr_bits;

    generate
        if (VA_BITS >= ADDR_W) begin : g_no_canon
            assign canonical = 1'b1;
        end else begin : g_canon
            localparam int HI_W = ADDR_W - VA_BITS + 1;
            logic [HI_W-1:0] hi_bits;
            assign hi_bits   = addr[ADDR_W-1:VA_BITS-1];
            assign canonical = (&hi_bits) | ~(|hi_bits);
        end
        if (ALIGN_BYTES > 1) begin : g_align
            assign misaligned = |addr[ALIGN_LSB-1:0];
        end else begin : g_noalign
            assign misaligned = 1'b0;
        end
    endgenerate

    assign unused_addr_bits = ^addr;

    // Fixed priority: mode, lock, control enable, ss enable, privilege, canonical, alignment
    always_comb begin
        fault = FLT_NONE;
        cause = CAUSE_NONE;
        if (mode == MODE_REAL || mode == MODE_V86) begin
            fault = FLT_UD;
            cause = CAUSE_MODE;
        end else if (lock_pfx) begin
            fault = FLT_UD;
            cause = CAUSE_LOCK;
        end else if (!ctl_en) begin
            fault = FLT_UD;
            cause = CAUSE_CTL;
        end else if (!ss_en) begin
            fault = FLT_UD;
            cause = CAUSE_SSEN;
        end else if (cpl != 2'd0) begin
            fault = FLT_GP;
            cause = CAUSE_PRIV;
        end else if (mode == MODE_LONG && !canonical) begin
            fault = FLT_GP;
            cause = CAUSE_CANON;
        end else if (misaligned) begin
            fault = FLT_GP;
            cause = CAUSE_ALIGN;
        end
    end

endmodule

// File: rtl/ssrel_token_xchg.sv
module ssrel_token_xchg import ssrel_pkg::*; #(
    parameter int ADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  addr,
    output logic               mem_rd_req,
    output logic               mem_wr_req,
    output logic               mem_lock,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [TOKEN_W-1:0] mem_wdata,
    input  logic [TOKEN_W-1:0] mem_rdata,
    input  logic               mem_rd_ack,
    input  logic               mem_wr_ack,
    input  logic               mem_fault,
    output logic               xc_done,
    output logic               xc_abort,
    output logic               xc_match
);

    typedef enum logic [1:0] {
        XIDLE  = 2'd0,
        XREAD  = 2'd1,
        XWRITE = 2'd2
    } xstate_e;

    xstate_e state, state_nx;

    logic [ADDR_W-1:0]  addr_q;
    logic [TOKEN_W-1:0] rd_hold;
    logic [TOKEN_W-1:0] tok_base;
    logic [TOKEN_W-1:0] tok_expect;
    logic [TOKEN_W-1:0] tok_free;

    always_comb begin
        tok_base = '0;
        tok_base[ADDR_W-1:0] = addr_q;
        tok_expect = tok_base | {{(TOKEN_W-1){1'b0}}, 1'b1};
        tok_free   = tok_base & ~{{(TOKEN_W-1){1'b0}}, 1'b1};
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            XIDLE:  if (start) state_nx = XREAD;
            XREAD: begin
                if (mem_fault)       state_nx = XIDLE;
                else if (mem_rd_ack) state_nx = XWRITE;
            end
            XWRITE: begin
                if (mem_fault || mem_wr_ack) state_nx = XIDLE;
            end
            default: state_nx = XIDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XIDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rd_hold  <= '0;
            xc_match <= 1'b0;
            xc_done  <= 1'b0;
            xc_abort <= 1'b0;
        end else begin
            xc_done  <= 1'b0;
            xc_abort <= 1'b0;
            unique case (state)
                XIDLE: if (start) addr_q <= addr;
                XREAD: begin
                    if (mem_fault) begin
                        xc_abort <= 1'b1;
                    end else if (mem_rd_ack) begin
                        rd_hold  <= mem_rdata;
                        xc_match <= (mem_rdata == tok_expect);
                    end
                end
                XWRITE: begin
                    if (mem_fault)       xc_abort <= 1'b1;
                    else if (mem_wr_ack) xc_done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_rd_req = (state == XREAD);
        mem_wr_req = (state == XWRITE);
        mem_lock   = (state == XREAD) || (state == XWRITE);
        mem_addr   = addr_q;
        mem_wdata  = xc_match ? tok_free : rd_hold;
    end

    // R6
    lock_covers_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> mem_lock);

    // R6
    lock_drops_after_wack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_ack && !mem_fault) |=> (!mem_lock && xc_done));

    // R11
    abort_releases_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && mem_fault) |=> (!mem_lock && xc_abort));

    // R6
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req) |-> $past(mem_rd_req && mem_rd_ack));

endmodule

// File: rtl/ssrel_token_release.sv
module ssrel_token_release import ssrel_pkg::*; #(
    parameter int ADDR_W        = 64,
    parameter int VA_BITS       = 48,
    parameter int ALIGN_BYTES   = 8,
    parameter bit LONG_TOKEN_GP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_mode,
    input  logic [1:0]         req_cpl,
    input  logic               req_lock_pfx,
    input  logic               cfg_ctl_en,
    input  logic               cfg_sup_ss_en,
    output logic               mem_rd_req,
    output logic               mem_wr_req,
    output logic               mem_lock,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [TOKEN_W-1:0] mem_wdata,
    input  logic [TOKEN_W-1:0] mem_rdata,
    input  logic               mem_rd_ack,
    input  logic               mem_wr_ack,
    input  logic               mem_fault,
    output logic               done,
    output logic [1:0]         fault_code,
    output logic [3:0]         fault_cause,
    output logic               flags_we,
    output logic               flag_cf,
    output logic               flag_zf,
    output logic               flag_pf,
    output logic               flag_af,
    output logic               flag_of,
    output logic               flag_sf,
    output logic               ssp_we,
    output logic [ADDR_W-1:0]  ssp_next
);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_CHECK  = 2'd1,
        S_XCHG   = 2'd2,
        S_FINISH = 2'd3
    } state_e;

    state_e state, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        mode_q;
    logic [1:0]        cpl_q;
    logic              lock_q;
    logic              ctl_q;
    logic              ss_q;
    logic [1:0]        fault_q;
    logic [3:0]        cause_q;
    logic              cf_q;

    logic [1:0]        chk_fault;
    logic [3:0]        chk_cause;
    logic              xc_start;
    logic              xc_done;
    logic              xc_abort;
    logic              xc_match;
    logic              token_gp;

    ssrel_fault_check #(
        .ADDR_W      (ADDR_W),
        .VA_BITS     (VA_BITS),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) u_check (
        .mode     (mode_q),
        .lock_pfx (lock_q),
        .ctl_en   (ctl_q),
        .ss_en    (ss_q),
        .cpl      (cpl_q),
        .addr     (addr_q),
        .fault    (chk_fault),
        .cause    (chk_cause)
    );

    assign xc_start = (state == S_CHECK) && (chk_fault == FLT_NONE);

    ssrel_token_xchg #(
        .ADDR_W (ADDR_W)
    ) u_xchg (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xc_start),
        .addr       (addr_q),
        .mem_rd_req (mem_rd_req),
        .mem_wr_req (mem_wr_req),
        .mem_lock   (mem_lock),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rd_ack (mem_rd_ack),
        .mem_wr_ack (mem_wr_ack),
        .mem_fault  (mem_fault),
        .xc_done    (xc_done),
        .xc_abort   (xc_abort),
        .xc_match   (xc_match)
    );

    assign token_gp = LONG_TOKEN_GP && (mode_q == MODE_LONG) && !xc_match;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_CHECK;
            S_CHECK: state_nx = (chk_fault != FLT_NONE) ? S_FINISH : S_XCHG;
            S_XCHG:  if (xc_abort || xc_done) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mode_q  <= MODE_REAL;
            cpl_q   <= '0;
            lock_q  <= 1'b0;
            ctl_q   <= 1'b0;
            ss_q    <= 1'b0;
            fault_q <= FLT_NONE;
            cause_q <= CAUSE_NONE;
            cf_q    <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        mode_q <= req_mode;
                        cpl_q  <= req_cpl;
                        lock_q <= req_lock_pfx;
                        ctl_q  <= cfg_ctl_en;
                        ss_q   <= cfg_sup_ss_en;
                    end
                end
                S_CHECK: begin
                    if (chk_fault != FLT_NONE) begin
                        fault_q <= chk_fault;
                        cause_q <= chk_cause;
                    end
                end
                S_XCHG: begin
                    if (xc_abort) begin
                        fault_q <= FLT_MEM;
                        cause_q <= CAUSE_MEM;
                    end else if (xc_done) begin
                        if (token_gp) begin
                            fault_q <= FLT_GP;
                            cause_q <= CAUSE_TOKEN;
                        end else begin
                            fault_q <= FLT_NONE;
                            cause_q <= CAUSE_NONE;
                            cf_q    <= !xc_match;
                        end
                    end
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        done        = (state == S_FINISH);
        fault_code  = done ? fault_q : FLT_NONE;
        fault_cause = done ? cause_q : CAUSE_NONE;
        flags_we    = done && (fault_q == FLT_NONE);
        ssp_we      = flags_we;
        ssp_next    = '0;
        flag_cf     = cf_q;
        flag_zf     = 1'b0;
        flag_pf     = 1'b0;
        flag_af     = 1'b0;
        flag_of     = 1'b0;
        flag_sf     = 1'b0;
    end

    // R2 (also R1): an early fault ends the request with no memory traffic
    early_fault_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && chk_fault != FLT_NONE) |=> (done && !mem_rd_req && !mem_lock));

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    valid_token_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XCHG && xc_done && xc_match) |=> (flags_we && ssp_we && !flag_cf));

    // R11
    abort_reports_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XCHG && xc_abort) |=> (done && fault_code == FLT_MEM && !flags_we));

    // R10
    fault_blocks_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != FLT_NONE) |-> (!flags_we && !ssp_we));

endmodule

// File: tb/ssrel_token_release_bench.sv
`timescale 1ns/1ps
module ssrel_token_release_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_cpl = '0;
    logic        req_lock_pfx = 1'b0;
    logic        cfg_ctl_en = 1'b0;
    logic        cfg_sup_ss_en = 1'b0;
    logic        mem_rd_req, mem_wr_req, mem_lock;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0, mem_fault = 1'b0;
    logic        done, flags_we, ssp_we;
    logic [1:0]  fault_code;
    logic [3:0]  fault_cause;
    logic        flag_cf, flag_zf, flag_pf, flag_af, flag_of, flag_sf;
    logic [63:0] ssp_next;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ssrel_token_release u_ssrel_token_release (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mode(req_mode), .req_cpl(req_cpl), .req_lock_pfx(req_lock_pfx),
        .cfg_ctl_en(cfg_ctl_en), .cfg_sup_ss_en(cfg_sup_ss_en),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd_ack(mem_rd_ack), .mem_wr_ack(mem_wr_ack), .mem_fault(mem_fault),
        .done(done), .fault_code(fault_code), .fault_cause(fault_cause),
        .flags_we(flags_we), .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_pf(flag_pf),
        .flag_af(flag_af), .flag_of(flag_of), .flag_sf(flag_sf),
        .ssp_we(ssp_we), .ssp_next(ssp_next)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // fault_at: 0 none, 1 during read phase, 2 during write phase
    task automatic run_case(string tag, logic [1:0] mode, logic lk, logic ctl, logic ss,
                            logic [1:0] cpl, logic [63:0] addr, logic [63:0] rd_val,
                            int fault_at, logic [1:0] exp_code, logic [3:0] exp_cause,
                            logic exp_access, logic exp_cf);
        logic [63:0] exp_wdata;
        bit saw_rd = 0;
        bit saw_wr = 0;
        bit got_done = 0;
        exp_wdata = (rd_val == (addr | 64'd1)) ? (addr & ~64'd1) : rd_val;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_mode = mode; req_cpl = cpl;
        req_lock_pfx = lk; cfg_ctl_en = ctl; cfg_sup_ss_en = ss;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 60 && !got_done; cyc++) begin
            if (cyc > 0) @(negedge clk);
            mem_rd_ack = 1'b0; mem_wr_ack = 1'b0; mem_fault = 1'b0;
            if (done) begin
                got_done = 1;
            end else if (mem_rd_req) begin
                saw_rd = 1;
                chk(tag, "lock during read (R6)", {63'd0, mem_lock}, 64'd1);
                chk(tag, "read address (R6)", mem_addr, addr);
                if (fault_at == 1) mem_fault = 1'b1;
                else begin mem_rdata = rd_val; mem_rd_ack = 1'b1; end
            end else if (mem_wr_req) begin
                saw_wr = 1;
                chk(tag, "lock during write (R6)", {63'd0, mem_lock}, 64'd1);
                chk(tag, "write data (R7 R8)", mem_wdata, exp_wdata);
                if (fault_at == 2) mem_fault = 1'b1;
                else mem_wr_ack = 1'b1;
            end
        end
        chk(tag, "done seen (R10)", {63'd0, got_done}, 64'd1);
        if (got_done) begin
            chk(tag, "fault code", {62'd0, fault_code}, {62'd0, exp_code});
            chk(tag, "fault cause", {60'd0, fault_cause}, {60'd0, exp_cause});
            chk(tag, "lock released (R6 R11)", {63'd0, mem_lock}, 64'd0);
            chk(tag, "memory read issued", {63'd0, saw_rd}, {63'd0, exp_access});
            chk(tag, "memory write issued", {63'd0, saw_wr},
                {63'd0, exp_access && fault_at != 1});
            if (exp_code == 2'd0) begin
                chk(tag, "flags_we/ssp_we (R9)", {62'd0, flags_we, ssp_we}, 64'd3);
                chk(tag, "ssp_next zero (R9)", ssp_next, 64'd0);
                chk(tag, "carry (R9)", {63'd0, flag_cf}, {63'd0, exp_cf});
                chk(tag, "other flags clear (R9)",
                    {59'd0, flag_zf, flag_pf, flag_af, flag_of, flag_sf}, 64'd0);
            end else begin
                chk(tag, "no flag/ssp write on fault (R10)", {62'd0, flags_we, ssp_we}, 64'd0);
            end
            @(negedge clk);
            chk(tag, "done one cycle (R10)", {63'd0, done}, 64'd0);
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        chk("reset", "outputs idle",
            {60'd0, done, mem_rd_req, mem_wr_req, mem_lock}, 64'd0);
        chk("reset", "write enables", {62'd0, flags_we, ssp_we}, 64'd0);
    endtask

    localparam logic [63:0] A_OK    = 64'h0000_7fff_ffff_f008;
    localparam logic [63:0] A_NC_MA = 64'h0000_8000_0000_0009;
    localparam logic [63:0] A_NC    = 64'h0000_8000_0000_0010;
    localparam logic [63:0] A_MA    = 64'h0000_0000_1000_0004;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_check();
        run_case("R1 real",    2'd0, 0, 1, 1, 2'd0, A_OK, 0, 0, 2'd1, 4'd1, 0, 0);
        run_case("R1 v86",     2'd1, 0, 1, 1, 2'd0, A_OK, 0, 0, 2'd1, 4'd1, 0, 0);
        run_case("R2 lock",    2'd2, 1, 0, 0, 2'd3, A_MA, 0, 0, 2'd1, 4'd2, 0, 0);
        run_case("R2 ctl",     2'd3, 0, 0, 0, 2'd3, A_OK, 0, 0, 2'd1, 4'd3, 0, 0);
        run_case("R2 ssen",    2'd2, 0, 1, 0, 2'd1, A_OK, 0, 0, 2'd1, 4'd4, 0, 0);
        run_case("R3 cpl",     2'd3, 0, 1, 1, 2'd3, A_NC_MA, 0, 0, 2'd2, 4'd5, 0, 0);
        run_case("R4 canon",   2'd3, 0, 1, 1, 2'd0, A_NC_MA, 0, 0, 2'd2, 4'd6, 0, 0);
        run_case("R4 prot",    2'd2, 0, 1, 1, 2'd0, A_NC, A_NC | 1, 0, 2'd0, 4'd0, 1, 0);
        run_case("R5 align",   2'd2, 0, 1, 1, 2'd0, A_MA, 0, 0, 2'd2, 4'd7, 0, 0);
        run_case("R7 match",   2'd2, 0, 1, 1, 2'd0, A_OK, A_OK | 1, 0, 2'd0, 4'd0, 1, 0);
        run_case("R8 mismatch", 2'd2, 0, 1, 1, 2'd0, A_OK, 64'h0000_0000_dead_beef, 0,
                 2'd0, 4'd0, 1, 1);
        run_case("R10 fault after cf", 2'd2, 0, 1, 1, 2'd2, A_OK, 0, 0, 2'd2, 4'd5, 0, 0);
        chk("R10 flags kept", "cf unchanged", {63'd0, flag_cf}, 64'd1);
        run_case("R9 long match", 2'd3, 0, 1, 1, 2'd0, A_OK, A_OK | 1, 0, 2'd0, 4'd0, 1, 0);
        run_case("R8 not busy", 2'd2, 0, 1, 1, 2'd0, A_OK, A_OK, 0, 2'd0, 4'd0, 1, 1);
        run_case("R12 long bad", 2'd3, 0, 1, 1, 2'd0, A_OK, 64'h1234, 0, 2'd2, 4'd8, 1, 0);
        run_case("R11 rd fault", 2'd2, 0, 1, 1, 2'd0, A_OK, A_OK | 1, 1, 2'd3, 4'd9, 1, 0);
        run_case("R11 wr fault", 2'd3, 0, 1, 1, 2'd0, A_OK, A_OK | 1, 2, 2'd3, 4'd9, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule